// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File

This block holds the floating-point register file of a processor. It has 32 entries of 64 bits, and each entry has a format tag. The tag records how the register was last written or first read: single, double, word (32-bit integer), long (64-bit integer), uninterpreted, or unknown. The block has one combinational read port and one write port. Each port carries a register index, a requested format and data.

A read in a format that conflicts with the register's tag does not return the stored bits. It returns a quiet-NaN pattern chosen by the requested format, and it downgrades the tag to unknown. A mode input sets the register width:
- **64-bit mode:** every register is a full 64-bit register.
- **32-bit mode:** only the low 32 bits of each register hold data, and 64-bit formats are carried by an even/odd register pair.

An illegal pair access on an odd register produces a one-cycle reserved-instruction pulse. The pipeline uses this pulse to trap.

In 64-bit mode, a 32-bit write fills the upper half of the register with the constant 0xDEADC0DE. This makes stale upper bits recognisable in a debugger. The filler is never visible through the read port, because narrow reads return only the low half.

Top module: `fpr_tagged_file`

## Requirements
- R1: Reset (synchronous, active high) sets all tags to uninterpreted, all registers to zero and `rsvd_instr` low. While `rd_en` is low, `rd_data` is zero.
- R2: The format code is shared by both ports: 0 uninterpreted, 1 single, 2 double, 3 word, 4 long. A read with a concrete format (codes 1 to 4) of an uninterpreted-tagged register adopts that format as the register's tag and returns the stored bits.
- R3: A read requesting uninterpreted (code 0) uses the register's current tag as its format and leaves the tag unchanged. When that tag is itself uninterpreted, the read returns the raw value in the 64-bit layout of the current mode. When that tag is unknown, the read returns zero.
- R4: A read with a concrete format that differs from a concrete tag sets the tag to unknown. That same read already returns the quiet NaN of R5.
- R5: A read of an unknown-tagged register with a concrete format returns 32'h7FBFFFFF for single, 32'h7FFFFFFF for word, 64'h7FF7FFFFFFFFFFFF for double and 64'h7FFFFFFFFFFFFFFF for long. 32-bit values are zero-extended.
- R6: A single or word read returns the low 32 bits of register n, zero-extended, in either mode.
- R7: In 32-bit mode, a double, long or uninterpreted-wide read of an even index n returns {low half of n+1, low half of n}. The same read on an odd index returns zero, changes no tag and raises `rsvd_instr`.
- R8: In 64-bit mode, a single or word write stores the value's low 32 bits (a later narrow read returns them) and sets the tag. A double, long or uninterpreted write stores all 64 bits and sets the tag.
- R9: In 32-bit mode, a single or word write stores the low 32 bits in n with a zero upper half. A wide write to an even n puts the low half in n and the high half in n+1 and tags both registers. A wide write to an odd n changes no data, tags n (and n+1 when it exists) unknown, and raises `rsvd_instr`.
- R10: Writes and tag updates take effect at the clock edge. A read in the same cycle sees the contents from before the edge. When a write and a read update the same tag at one edge, the write's tag wins.
- R11: `rsvd_instr` is high exactly in the cycle following an edge at which an illegal access (R7, R9) was presented, and is low otherwise.
- R12: Format codes 5 to 7 are not valid. A write with such a code changes nothing. A read with such a code returns zero and changes no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1: 64-bit registers, 0: 32-bit registers with pairs |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Read register index |
| rd_fmt | input | 3 | Requested read format code |
| rd_data | output | 64 | Combinational read result |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_fmt | input | 3 | Write format code |
| wr_data | input | 64 | Write data |
| rsvd_instr | output | 1 | One-cycle reserved-instruction pulse |

## Verification
The hardest state to reach from the ports is an unknown tag on the partner register of an odd pair write. The case where a read and a write update the same tag at one edge is equally hard to reach. To reach these, directed sequences switch the block into 32-bit mode and write a double to an odd index, including index 31, and then read both neighbours. They also issue a same-cycle read and write on one index with different formats. A long random phase keeps indices clustered at the two ends of the file and toggles the mode periodically, so that pair writes, conflicting reads and collisions recur. A behavioural model is compared on every cycle.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int IDX_W = 5;
    localparam int DW    = 64;
    localparam int HW    = DW / 2;
    localparam int NREG  = 2 ** IDX_W;

    localparam logic [HW-1:0] FILL_MARK = 32'hDEADC0DE;

    typedef enum logic [2:0] {
        FMT_UNINT   = 3'd0,
        FMT_SINGLE  = 3'd1,
        FMT_DOUBLE  = 3'd2,
        FMT_WORD    = 3'd3,
        FMT_LONG    = 3'd4,
        FMT_UNKNOWN = 3'd5
    } fmt_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        fmt_e             tag;
    } tag_upd_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    data;
    } data_upd_t;

    // codes above long are not valid requests
    function automatic logic code_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    // formats whose value spans the full 64 bits
    function automatic logic is_wide(input fmt_e f);
        return (f == FMT_DOUBLE) || (f == FMT_LONG) || (f == FMT_UNINT);
    endfunction

    function automatic logic is_narrow(input fmt_e f);
        return (f == FMT_SINGLE) || (f == FMT_WORD);
    endfunction

    function automatic logic [DW-1:0] qnan_of(input fmt_e f);
        case (f)
            FMT_SINGLE: return {{HW{1'b0}}, 32'h7FBFFFFF};
            FMT_WORD:   return {{HW{1'b0}}, 32'h7FFFFFFF};
            FMT_DOUBLE: return 64'h7FF7FFFFFFFFFFFF;
            FMT_LONG:   return 64'h7FFFFFFFFFFFFFFF;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/fprf_rd_path.sv
module fprf_rd_path
    import fprf_pkg::*;
(
    input  logic             mode64,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [2:0]       rd_fmt,
    input  fmt_e             tag_n,
    input  logic [DW-1:0]    reg_n,
    input  logic [DW-1:0]    reg_n1,
    output logic [DW-1:0]    rd_data,
    output tag_upd_t         tag_upd,
    output logic             illegal
);

    fmt_e req;
    fmt_e eff;
    logic conflict;
    logic poisoned;

    always_comb begin
        req      = fmt_e'(rd_fmt);
        eff      = (req == FMT_UNINT) ? tag_n : req;
        conflict = (req != FMT_UNINT) && (tag_n != FMT_UNINT) && (tag_n != req);
        poisoned = conflict || (tag_n == FMT_UNKNOWN);
        rd_data  = '0;
        tag_upd  = '{en: 1'b0, idx: rd_idx, tag: FMT_UNINT};
        illegal  = 1'b0;
        if (rd_en && code_ok(rd_fmt)) begin
            if (!mode64 && rd_idx[0] && is_wide(eff)) begin
                illegal = 1'b1;
            end else begin
                if (req != FMT_UNINT && tag_n == FMT_UNINT) begin
                    tag_upd.en  = 1'b1;
                    tag_upd.tag = req;
                end else if (conflict && tag_n != FMT_UNKNOWN) begin
                    tag_upd.en  = 1'b1;
                    tag_upd.tag = FMT_UNKNOWN;
                end
                if (poisoned) begin
                    rd_data = qnan_of(eff);
                end else if (is_wide(eff)) begin
                    rd_data = mode64 ? reg_n : {reg_n1[HW-1:0], reg_n[HW-1:0]};
                end else begin
                    rd_data = {{HW{1'b0}}, reg_n[HW-1:0]};
                end
            end
        end
    end

endmodule

// File: rtl/fprf_wr_path.sv
module fprf_wr_path
    import fprf_pkg::*;
(
    input  logic             mode64,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_fmt,
    input  logic [DW-1:0]    wr_data,
    output data_upd_t        dat_lo,
    output data_upd_t        dat_hi,
    output tag_upd_t         tag_lo,
    output tag_upd_t         tag_hi,
    output logic             illegal
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

    fmt_e             fmt;
    logic [IDX_W-1:0] pair_idx;
    logic [HW-1:0]    lo_half;
    logic [HW-1:0]    hi_half;

    always_comb begin
        fmt      = fmt_e'(wr_fmt);
        pair_idx = wr_idx + IDX_W'(1);
        lo_half  = wr_data[HW-1:0];
        hi_half  = wr_data[DW-1:HW];
        dat_lo   = '{en: 1'b0, idx: wr_idx,   data: '0};
        dat_hi   = '{en: 1'b0, idx: pair_idx, data: '0};
        tag_lo   = '{en: 1'b0, idx: wr_idx,   tag: fmt};
        tag_hi   = '{en: 1'b0, idx: pair_idx, tag: fmt};
        illegal  = 1'b0;
        if (wr_en && code_ok(wr_fmt)) begin
            if (mode64) begin
                dat_lo.en   = 1'b1;
                dat_lo.data = is_narrow(fmt) ? {FILL_MARK, lo_half} : wr_data;
                tag_lo.en   = 1'b1;
            end else if (is_narrow(fmt)) begin
                dat_lo.en   = 1'b1;
                dat_lo.data = {{HW{1'b0}}, lo_half};
                tag_lo.en   = 1'b1;
            end else if (!wr_idx[0]) begin
                dat_lo.en   = 1'b1;
                dat_lo.data = {{HW{1'b0}}, lo_half};
                dat_hi.en   = 1'b1;
                dat_hi.data = {{HW{1'b0}}, hi_half};
                tag_lo.en   = 1'b1;
                tag_hi.en   = 1'b1;
            end else begin
                illegal    = 1'b1;
                tag_lo.en  = 1'b1;
                tag_lo.tag = FMT_UNKNOWN;
                tag_hi.en  = (wr_idx != LAST_IDX);
                tag_hi.tag = FMT_UNKNOWN;
            end
        end
    end

endmodule

// File: rtl/fprf_store.sv
module fprf_store
    import fprf_pkg::*;
#(
    parameter int ENTRIES = NREG
) (
    input  logic             clk,
    input  logic             rst,
    input  data_upd_t        dat_lo,
    input  data_upd_t        dat_hi,
    input  tag_upd_t         tag_lo,
    input  tag_upd_t         tag_hi,
    input  tag_upd_t         tag_rd,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    reg_n,
    output logic [DW-1:0]    reg_n1,
    output fmt_e             tag_n
);

    logic [DW-1:0] regs [ENTRIES];
    fmt_e          tags [ENTRIES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) begin
                regs[i] <= '0;
                tags[i] <= FMT_UNINT;
            end else begin
                if (dat_lo.en && dat_lo.idx == IDX_W'(i)) begin
                    regs[i] <= dat_lo.data;
                end else if (dat_hi.en && dat_hi.idx == IDX_W'(i)) begin
                    regs[i] <= dat_hi.data;
                end
                // write-side tag updates override the read-side one
                if (tag_lo.en && tag_lo.idx == IDX_W'(i)) begin
                    tags[i] <= tag_lo.tag;
                end else if (tag_hi.en && tag_hi.idx == IDX_W'(i)) begin
                    tags[i] <= tag_hi.tag;
                end else if (tag_rd.en && tag_rd.idx == IDX_W'(i)) begin
                    tags[i] <= tag_rd.tag;
                end
            end
        end
    end

    assign reg_n  = regs[rd_idx];
    assign reg_n1 = regs[rd_idx | IDX_W'(1)];
    assign tag_n  = tags[rd_idx];

endmodule

// File: rtl/fpr_tagged_file.sv
module fpr_tagged_file
    import fprf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode64,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [2:0]       rd_fmt,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_fmt,
    input  logic [DW-1:0]    wr_data,
    output logic             rsvd_instr
);

    data_upd_t     dat_lo, dat_hi;
    tag_upd_t      tag_lo, tag_hi, tag_rd;
    logic          ill_rd, ill_wr;
    logic [DW-1:0] reg_n, reg_n1;
    fmt_e          tag_n;

    fprf_rd_path u_rd (
        .mode64 (mode64),
        .rd_en  (rd_en),
        .rd_idx (rd_idx),
        .rd_fmt (rd_fmt),
        .tag_n  (tag_n),
        .reg_n  (reg_n),
        .reg_n1 (reg_n1),
        .rd_data(rd_data),
        .tag_upd(tag_rd),
        .illegal(ill_rd)
    );

    fprf_wr_path u_wr (
        .mode64 (mode64),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_fmt (wr_fmt),
        .wr_data(wr_data),
        .dat_lo (dat_lo),
        .dat_hi (dat_hi),
        .tag_lo (tag_lo),
        .tag_hi (tag_hi),
        .illegal(ill_wr)
    );

    fprf_store #(.ENTRIES(NREG)) u_store (
        .clk   (clk),
        .rst   (rst),
        .dat_lo(dat_lo),
        .dat_hi(dat_hi),
        .tag_lo(tag_lo),
        .tag_hi(tag_hi),
        .tag_rd(tag_rd),
        .rd_idx(rd_idx),
        .reg_n (reg_n),
        .reg_n1(reg_n1),
        .tag_n (tag_n)
    );

    always_ff @(posedge clk) begin
        if (rst) rsvd_instr <= 1'b0;
        else     rsvd_instr <= ill_rd | ill_wr;
    end

endmodule

// File: rtl/fpr_tagged_file_chk.sv
module fpr_tagged_file_chk
    import fprf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mode64,
    input logic             rd_en,
    input logic [IDX_W-1:0] rd_idx,
    input logic [2:0]       rd_fmt,
    input logic [DW-1:0]    rd_data,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [2:0]       wr_fmt,
    input logic             rsvd_instr
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !rsvd_instr);

    assert_odd_pair_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !mode64 && rd_idx[0] && (rd_fmt == 3'd2 || rd_fmt == 3'd4)) |-> rd_data == '0);

    assert_odd_pair_read_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !mode64 && rd_idx[0] && (rd_fmt == 3'd2 || rd_fmt == 3'd4)) |=> rsvd_instr);

    assert_odd_pair_write_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mode64 && wr_idx[0] && (wr_fmt == 3'd0 || wr_fmt == 3'd2 || wr_fmt == 3'd4)) |=> rsvd_instr);

    assert_flag_has_cause_R11: assert property (@(posedge clk) disable iff (rst)
        rsvd_instr |-> $past(rd_en || wr_en));

    assert_narrow_read_width_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_fmt == 3'd1 || rd_fmt == 3'd3)) |-> rd_data[DW-1:HW] == '0);

    assert_bad_code_read_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_fmt > 3'd4) |-> rd_data == '0);

endmodule

bind fpr_tagged_file fpr_tagged_file_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode64    (mode64),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .rd_fmt    (rd_fmt),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_fmt    (wr_fmt),
    .rsvd_instr(rsvd_instr)
);

// File: tb/tb_fpr_tagged_file.sv
module tb_fpr_tagged_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode64 = 1'b1;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [2:0]  rd_fmt = '0;
    logic [63:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [2:0]  wr_fmt = '0;
    logic [63:0] wr_data = '0;
    logic        rsvd_instr;

    int vectors = 0;
    int miscompares = 0;

    // model state: tag codes 0 unint,1 single,2 double,3 word,4 long,5 unknown
    logic [63:0] m_reg [32];
    int          m_tag [32];
    bit          exp_flag = 0;

    always #10 clk = ~clk;

    fpr_tagged_file dut (
        .clk(clk), .rst(rst), .mode64(mode64),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_fmt(rd_fmt), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt), .wr_data(wr_data),
        .rsvd_instr(rsvd_instr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] nan_for(input int f);
        case (f)
            1: return 64'h000000007FBFFFFF;
            3: return 64'h000000007FFFFFFF;
            2: return 64'h7FF7FFFFFFFFFFFF;
            4: return 64'h7FFFFFFFFFFFFFFF;
            default: return 64'h0;
        endcase
    endfunction

    function automatic void model_read(input bit m64, input bit en, input int idx, input int rf,
                                       output logic [63:0] d, output bit ill,
                                       output bit tu, output int tv, output string why);
        int t;
        int e;
        bit wide;
        bit clash;
        d = 64'h0; ill = 0; tu = 0; tv = 0; why = "R1";
        if (!en) return;
        if (rf > 4) begin why = "R12"; return; end
        t = m_tag[idx];
        e = (rf == 0) ? t : rf;
        wide = (e == 0) || (e == 2) || (e == 4);
        if (!m64 && (idx % 2 == 1) && wide) begin ill = 1; why = "R7"; return; end
        clash = (rf != 0) && (t != 0) && (t != rf);
        if (rf != 0 && t == 0) begin tu = 1; tv = rf; end
        else if (clash && t != 5) begin tu = 1; tv = 5; end
        if (t == 5) begin d = nan_for(e); why = "R5"; end
        else if (clash) begin d = nan_for(e); why = "R4"; end
        else if (wide) begin
            d = m64 ? m_reg[idx] : {m_reg[idx + 1][31:0], m_reg[idx][31:0]};
            why = (rf == 0) ? "R3" : (m64 ? "R2" : "R7");
        end else begin
            d = {32'h0, m_reg[idx][31:0]};
            why = "R6";
        end
    endfunction

    function automatic bit model_write(input bit m64, input bit en, input int idx, input int wf,
                                       input logic [63:0] v);
        bit narrow;
        if (!en || wf > 4) return 0;
        narrow = (wf == 1) || (wf == 3);
        if (m64) begin
            m_reg[idx] = narrow ? {32'hDEADC0DE, v[31:0]} : v;
            m_tag[idx] = wf;
        end else if (narrow) begin
            m_reg[idx] = {32'h0, v[31:0]};
            m_tag[idx] = wf;
        end else if (idx % 2 == 0) begin
            m_reg[idx] = {32'h0, v[31:0]};
            m_reg[idx + 1] = {32'h0, v[63:32]};
            m_tag[idx] = wf;
            m_tag[idx + 1] = wf;
        end else begin
            m_tag[idx] = 5;
            if (idx < 31) m_tag[idx + 1] = 5;
            return 1;
        end
        return 0;
    endfunction

    // inputs are already set at a falling edge; compare, then advance one edge
    task automatic step(input string lbl);
        logic [63:0] ed;
        bit ill, tu, illw;
        int tv;
        string why;
        #5;
        model_read(mode64, rd_en, int'(rd_idx), int'(rd_fmt), ed, ill, tu, tv, why);
        if (lbl != "") why = lbl;
        check(rd_data === ed, why, rd_data, ed);
        check(rsvd_instr === exp_flag, "R11", {63'h0, rsvd_instr}, {63'h0, exp_flag});
        @(posedge clk);
        if (tu) m_tag[rd_idx] = tv;
        illw = model_write(mode64, wr_en, int'(wr_idx), int'(wr_fmt), wr_data);
        exp_flag = ill | illw;
        @(negedge clk);
    endtask

    task automatic op(input bit m64, input bit re, input int ri, input int rf,
                      input bit we, input int wi, input int wf, input logic [63:0] wd,
                      input string lbl);
        mode64 = m64;
        rd_en = re; rd_idx = 5'(ri); rd_fmt = 3'(rf);
        wr_en = we; wr_idx = 5'(wi); wr_fmt = 3'(wf); wr_data = wd;
        step(lbl);
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog R11: got 0 expected 1 (run did not complete)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_reg[i] = 64'h0; m_tag[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        check(rsvd_instr === 1'b0, "R1", {63'h0, rsvd_instr}, 64'h0);
        check(rd_data === 64'h0, "R1", rd_data, 64'h0);
        @(negedge clk);
        // R1: every register reads zero, raw, after reset
        for (int i = 0; i < 32; i++) op(1, 1, i, 0, 0, 0, 0, 0, "R1");

        // R2 adopt, R4 conflict, R5 unknown
        op(1, 1, 3, 1, 0, 0, 0, 0, "R2");
        op(1, 1, 3, 1, 0, 0, 0, 0, "R2");
        op(1, 1, 3, 2, 0, 0, 0, 0, "R4");
        op(1, 1, 3, 1, 0, 0, 0, 0, "R5");
        op(1, 1, 3, 4, 0, 0, 0, 0, "R5");
        op(1, 1, 3, 3, 0, 0, 0, 0, "R5");
        op(1, 1, 3, 0, 0, 0, 0, 0, "R3");

        // R8 64-bit mode writes
        op(1, 0, 0, 0, 1, 7, 3, 64'h1122334455667788, "");
        op(1, 1, 7, 3, 0, 0, 0, 0, "R8");
        op(1, 0, 0, 0, 1, 8, 4, 64'hCAFEF00D12345678, "");
        op(1, 1, 8, 4, 0, 0, 0, 0, "R8");
        op(1, 0, 0, 0, 1, 9, 0, 64'h0123456789ABCDEF, "");
        op(1, 1, 9, 0, 0, 0, 0, 0, "R8");

        // R9 / R7 in 32-bit mode
        op(0, 0, 0, 0, 1, 10, 2, 64'hAAAABBBBCCCCDDDD, "");
        op(0, 1, 10, 2, 0, 0, 0, 0, "R9");
        op(0, 1, 11, 0, 0, 0, 0, 0, "R7");
        op(0, 1, 12, 0, 0, 0, 0, 0, "R7");
        op(0, 1, 11, 4, 0, 0, 0, 0, "R7");
        op(0, 0, 0, 0, 1, 13, 4, 64'h5555666677778888, "R9");
        op(0, 1, 13, 1, 0, 0, 0, 0, "R9");
        op(0, 1, 14, 3, 0, 0, 0, 0, "R9");
        op(0, 0, 0, 0, 1, 31, 2, 64'h1, "R9");
        op(0, 1, 31, 1, 0, 0, 0, 0, "R9");
        op(0, 1, 0, 1, 0, 0, 0, 0, "R11");
        op(0, 0, 0, 0, 1, 16, 1, 64'hFFFFFFFF89ABCDEF, "");
        op(0, 1, 16, 1, 0, 0, 0, 0, "R6");
        op(1, 1, 16, 1, 0, 0, 0, 0, "R6");

        // R10 same-cycle read sees old; write tag wins
        op(1, 0, 0, 0, 1, 20, 4, 64'h1111111111111111, "");
        op(1, 1, 20, 4, 1, 20, 4, 64'h2222222222222222, "R10");
        op(1, 1, 20, 4, 0, 0, 0, 0, "R10");
        op(1, 1, 21, 1, 1, 21, 2, 64'h3333333333333333, "R10");
        op(1, 1, 21, 2, 0, 0, 0, 0, "R10");

        // R12 invalid codes
        op(1, 0, 0, 0, 1, 22, 6, 64'hFFFF, "");
        op(1, 1, 22, 7, 0, 0, 0, 0, "R12");
        op(1, 1, 22, 0, 0, 0, 0, 0, "R12");

        // R3 raw pair read in 32-bit mode
        op(0, 0, 0, 0, 1, 24, 0, 64'h9999888877776666, "");
        op(0, 1, 24, 0, 0, 0, 0, 0, "R3");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int sel;
            int ri, wi, rf, wf, fsel;
            if (n % 60 == 0) mode64 = $urandom % 2;
            sel = $urandom % 4;
            ri = (sel < 2) ? ($urandom % 4) : ((sel == 2) ? 28 + ($urandom % 4) : ($urandom % 32));
            sel = $urandom % 4;
            wi = (sel < 2) ? ($urandom % 4) : ((sel == 2) ? 28 + ($urandom % 4) : ($urandom % 32));
            fsel = $urandom % 10;
            rf = (fsel < 9) ? (fsel % 5) : 5 + ($urandom % 3);
            fsel = $urandom % 10;
            wf = (fsel < 9) ? (fsel % 5) : 5 + ($urandom % 3);
            op(mode64, ($urandom % 4) != 0, ri, rf, ($urandom % 3) == 0, wi, wf,
               {$urandom, $urandom}, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule